// File: doc/BRIEF.md
# Half-Duplex Transmit/Receive Lock Gate

This block sits between the electrical data pins and the optical front end of a half-duplex fibre transceiver. It passes the active-low electrical data input to the LED drive, inverting it so that a low input lights the LED. It passes the received optical level to an active-low receive output, so that light pulls the output low. Activity on one channel blocks the other channel, so that the transceiver does not hear its own transmission and does not transmit over a burst it is receiving.

Each channel that gets through arms its own hold timer. The opposite channel stays blocked while the input is active and for a programmable number of time-base ticks after the activity ends. New activity during the hold restarts the timer. When both channels wake in the same cycle, the transmit channel wins. A continuous-light flag, which comes from a classifier outside this block, forces the transmit side open so that a node can still drive a bus that is jammed with light. An external quiet input forces both outputs to their idle levels and drops any lock that is held.

Top module: `hdx_lock_gate`

## Requirements
- R1: When the transmit channel is not blocked, `led_drive` is 1 while `tx_data_n` is 0 and 0 while `tx_data_n` is 1, in the same cycle.
- R2: When the receive channel is not blocked, `rx_data_n` is 0 while `rx_light` is 1 and 1 while `rx_light` is 0, in the same cycle.
- R3: While the transmit channel is passing or holding, `rx_data_n` stays 1 whatever `rx_light` does. While the receive channel is passing or holding (and `cont_light` is 0), `led_drive` stays 0 whatever `tx_data_n` does.
- R4: After the last cycle of passed activity, the opposite channel stays blocked for `HOLD_TX` ticks (after transmit) or `HOLD_RX` ticks (after receive). With `tick` high every cycle, it passes again on the clock edge that ends the last of those ticks.
- R5: Activity that passes during a hold reloads that channel's timer to its full value.
- R6: If both channels become active in the same cycle while no lock is held, the transmit data reaches `led_drive` and `rx_data_n` stays 1.
- R7: While `cont_light` is 1, the transmit data reaches `led_drive` even during a receive lock. That transmit activity then takes the lock and blocks the receiver.
- R8: While `hold_quiet` is 1, `led_drive` is 0 and `rx_data_n` is 1, and any lock present is cleared at the next edge.
- R9: Hold timers advance only on clock edges where `tick` is 1. While `tick` stays 0, a lock is never released.
- R10: After a synchronous reset (`rst_n` low at a clock edge) no lock is held: `led_drive` is 0 and `rx_data_n` is 1 with idle inputs, and either channel passes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base pulse; one per hold unit |
| tx_data_n | input | 1 | Electrical data input, low = light the LED |
| rx_light | input | 1 | Received optical level, 1 = light present |
| cont_light | input | 1 | Continuous light detected; opens the transmit side |
| hold_quiet | input | 1 | Forces both outputs idle and clears the locks |
| led_drive | output | 1 | LED drive, 1 = LED on |
| rx_data_n | output | 1 | Receive data output, low = light received |

## Verification
A short vector table walks through the basic patterns: idle, receive only, a transmit attempt during a receive burst, a continuous-light takeover and a quiet interval. This shows plain passing separately from gating. Directed sequences then count edges after a trailing edge on each channel and confirm release on the exact edge. A retriggered burst tells a restarting timer from one that only runs down. A simultaneous start checks the transmit-first rule, and a long stretch with `tick` low shows that the hold is measured in ticks, not clock cycles.

// File: rtl/hdx_lock_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the half-duplex lock gate.
// Assumes hold lengths are positive integers counted in time-base ticks.
package hdx_lock_pkg;

    // Channel index used to select timers in generate loops.
    typedef enum int {
        CH_TX = 0,
        CH_RX = 1
    } hdx_chan_e;

    localparam int NUM_CHAN = 2;

    // Bits needed to hold a count from 0 up to a hold length.
    function automatic int hold_width(input int hold_len);
        return (hold_len < 1) ? 1 : $clog2(hold_len + 1);
    endfunction

endpackage

// File: rtl/hdx_hold_timer.sv
`timescale 1ns/1ps
// Module: retriggerable hold timer for one channel.
// Reloads to HOLD on each cycle of passed activity and counts down one step
// per tick. 'live' is high while a non-zero count remains.
// Assumes: HOLD >= 1; clr has priority over arm.
module hdx_hold_timer
    import hdx_lock_pkg::*;
#(
    parameter int HOLD = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic clr,
    output logic live
);

    localparam int            W      = hold_width(HOLD);
    localparam logic [W-1:0]  HOLD_V = W'(HOLD);
    localparam logic [W-1:0]  ONE_V  = W'(1);

    logic [W-1:0] cnt;

    // Count register: clear, reload on activity, or run down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= HOLD_V;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - ONE_V;
        end
    end

    // Lock indication derived from the remaining count.
    always_comb begin
        live = (cnt != '0);
    end

    AST_RELOAD_ON_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clr) |=> (cnt == HOLD_V)); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= HOLD_V); // R4

    AST_FREEZE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm && !clr) |=> $stable(cnt)); // R9

    AST_CLEAR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !live); // R8

endmodule

// File: rtl/hdx_lock_arbiter.sv
`timescale 1ns/1ps
// Module: decides which channel's data may pass in the current cycle.
// Transmit wins a tie from idle. A held receive lock blocks transmit unless
// continuous light is flagged. A held or current transmit blocks receive.
// Assumes: tx_live and rx_live come from registered timers.
module hdx_lock_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic cont_light,
    input  logic hold_quiet,
    input  logic tx_live,
    input  logic rx_live,
    output logic tx_pass,
    output logic rx_pass
);

    logic tx_grant;
    logic rx_grant;

    // Transmit may pass unless the receiver holds the lock (continuous light overrides).
    always_comb begin
        tx_grant = !rx_live || cont_light;
        tx_pass  = tx_act && tx_grant;
    end

    // Receive may pass only if transmit neither holds nor is passing now.
    always_comb begin
        rx_grant = !tx_live && !tx_pass;
        rx_pass  = rx_act && rx_grant;
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_live && rx_live)); // R3

    AST_TX_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_act && rx_act && !tx_live && !rx_live && !hold_quiet) |-> (tx_pass && !rx_pass)); // R6

    AST_CL_OPENS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_light && tx_act) |-> tx_pass); // R7

    AST_RX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tx_live |-> !rx_pass); // R3

endmodule

// File: rtl/hdx_out_stage.sv
`timescale 1ns/1ps
// Module: output polarity and forced-idle stage.
// Drives the LED high for passed transmit activity and pulls the receive
// output low for passed light. The quiet input overrides both.
// Assumes: inputs are already arbitrated pass flags.
module hdx_out_stage (
    input  logic tx_pass,
    input  logic rx_pass,
    input  logic hold_quiet,
    output logic led_drive,
    output logic rx_data_n
);

    // Apply polarity and the quiet override.
    always_comb begin
        led_drive = tx_pass && !hold_quiet;
        rx_data_n = !(rx_pass && !hold_quiet);
    end

endmodule

// File: rtl/hdx_lock_gate.sv
`timescale 1ns/1ps
// Module: top of the half-duplex transmit/receive lock gate.
// Converts pin polarity into activity flags, arbitrates the channels, runs
// one retriggerable hold timer per channel and drives the gated outputs.
// Assumes: tick is a single-cycle pulse in the clk domain; inputs are synchronous.
module hdx_lock_gate
    import hdx_lock_pkg::*;
#(
    parameter int HOLD_TX = 9,
    parameter int HOLD_RX = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_data_n,
    input  logic rx_light,
    input  logic cont_light,
    input  logic hold_quiet,
    output logic led_drive,
    output logic rx_data_n
);

    logic tx_act;
    logic rx_act;
    logic tx_pass;
    logic rx_pass;
    logic [NUM_CHAN-1:0] arm_v;
    logic [NUM_CHAN-1:0] clr_v;
    logic [NUM_CHAN-1:0] live_v;

    // Activity flags: a low electrical input and light at the receiver.
    always_comb begin
        tx_act = !tx_data_n;
        rx_act = rx_light;
    end

    // Timer controls: passed activity arms; a transmit takeover clears the receive lock.
    always_comb begin
        arm_v[CH_TX] = tx_pass;
        arm_v[CH_RX] = rx_pass;
        clr_v[CH_TX] = hold_quiet;
        clr_v[CH_RX] = hold_quiet || tx_pass;
    end

    hdx_lock_arbiter u_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_act     (tx_act),
        .rx_act     (rx_act),
        .cont_light (cont_light),
        .hold_quiet (hold_quiet),
        .tx_live    (live_v[CH_TX]),
        .rx_live    (live_v[CH_RX]),
        .tx_pass    (tx_pass),
        .rx_pass    (rx_pass)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_timer
        localparam int HOLD_C = (c == int'(CH_TX)) ? HOLD_TX : HOLD_RX;
        hdx_hold_timer #(
            .HOLD (HOLD_C)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .arm   (arm_v[c]),
            .clr   (clr_v[c]),
            .live  (live_v[c])
        );
    end

    hdx_out_stage u_out (
        .tx_pass    (tx_pass),
        .rx_pass    (rx_pass),
        .hold_quiet (hold_quiet),
        .led_drive  (led_drive),
        .rx_data_n  (rx_data_n)
    );

    AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_quiet |-> (!led_drive && rx_data_n)); // R8

    AST_TX_HOLD_MUTES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        live_v[CH_TX] |-> rx_data_n); // R3

    AST_RX_HOLD_MUTES_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (live_v[CH_RX] && !cont_light) |-> !led_drive); // R3

    AST_QUIET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_quiet |=> !(live_v[CH_TX] || live_v[CH_RX])); // R8

endmodule

// File: tb/hdx_lock_gate_bench.sv
`timescale 1ns/1ps
// Bench: vector table followed by directed hold, retrigger, tie and tick tests.
module hdx_lock_gate_bench;

    localparam int HOLD_TX = 9;
    localparam int HOLD_RX = 5;
    localparam int NVEC    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic tx_data_n = 1'b1;
    logic rx_light = 1'b0;
    logic cont_light = 1'b0;
    logic hold_quiet = 1'b0;
    logic led_drive;
    logic rx_data_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdx_lock_gate #(.HOLD_TX(HOLD_TX), .HOLD_RX(HOLD_RX)) u_hdx_lock_gate (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_data_n(tx_data_n),
        .rx_light(rx_light), .cont_light(cont_light), .hold_quiet(hold_quiet),
        .led_drive(led_drive), .rx_data_n(rx_data_n)
    );

    // Row: {req[3:0], tx_data_n, rx_light, cont_light, hold_quiet, exp_led, exp_rxn}
    // One row per cycle, tick high, starting from a freshly reset block.
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd10, 4'b1000, 2'b01},  // R10 idle after reset
        {4'd2,  4'b1100, 2'b00},  // R2 light passes, receive lock armed
        {4'd3,  4'b0100, 2'b00},  // R3 transmit blocked during receive
        {4'd2,  4'b1000, 2'b01},  // R2 dark gives high output
        {4'd3,  4'b0000, 2'b01},  // R3 receive hold still blocks transmit
        {4'd7,  4'b0110, 2'b11},  // R7 continuous light opens transmit, mutes receive
        {4'd7,  4'b1100, 2'b01},  // R7 transmit now holds the lock
        {4'd8,  4'b0101, 2'b01},  // R8 quiet forces idle levels
        {4'd8,  4'b1100, 2'b00},  // R8 lock cleared by quiet
        {4'd2,  4'b1000, 2'b01}   // R2 dark again
    };

    task automatic check(input string tag, input logic exp_led, input logic exp_rxn);
        checks++;
        if (led_drive !== exp_led || rx_data_n !== exp_rxn) begin
            failures++;
            $display("FAIL %s: led_drive=%b rx_data_n=%b expected led_drive=%b rx_data_n=%b",
                     tag, led_drive, rx_data_n, exp_led, exp_rxn);
        end
    endtask

    task automatic drive(input logic txn, input logic li, input logic cl, input logic hq);
        tx_data_n  = txn;
        rx_light   = li;
        cont_light = cl;
        hold_quiet = hq;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < HOLD_TX + HOLD_RX + 2; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        step();
        step();
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Vector table walk.
        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
            checks++;
            if (led_drive !== VEC[v][1] || rx_data_n !== VEC[v][0]) begin
                failures++;
                $display("FAIL R%0d row %0d: led_drive=%b rx_data_n=%b expected led_drive=%b rx_data_n=%b",
                         VEC[v][9:6], v, led_drive, rx_data_n, VEC[v][1], VEC[v][0]);
            end
            step();
        end

        // R10: reset state and no residual lock.
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        step();
        do_reset();
        check("R10 idle after reset", 1'b0, 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 receive free after reset", 1'b0, 1'b0);
        go_idle();

        // R1: transmit polarity.
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 low input lights LED", 1'b1, 1'b1);
        step();
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check("R1 high input turns LED off", 1'b0, 1'b1);
        go_idle();

        // R4: transmit hold length.
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        for (int j = 1; j < HOLD_TX; j++) step();
        check("R4 receive blocked on last transmit hold edge", 1'b0, 1'b1);
        step();
        check("R4 receive released after transmit hold", 1'b0, 1'b0);
        go_idle();

        // R4: receive hold length.
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        step();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        for (int j = 1; j < HOLD_RX; j++) step();
        check("R4 transmit blocked on last receive hold edge", 1'b0, 1'b1);
        step();
        check("R4 transmit released after receive hold", 1'b1, 1'b1);
        go_idle();

        // R5: retrigger restarts the full hold.
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        for (int j = 0; j < 5; j++) step();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        for (int j = 1; j < HOLD_TX; j++) step();
        check("R5 retriggered hold still blocks", 1'b0, 1'b1);
        step();
        check("R5 released after restarted hold", 1'b0, 1'b0);
        go_idle();

        // R6: simultaneous start favours transmit.
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 tie goes to transmit", 1'b1, 1'b1);
        step();
        check("R6 receive stays blocked", 1'b1, 1'b1);
        go_idle();

        // R9: no tick, no release.
        tick = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        for (int j = 0; j < 3 * HOLD_TX; j++) step();
        check("R9 hold frozen without tick", 1'b0, 1'b1);
        tick = 1'b1;
        for (int j = 0; j < HOLD_TX; j++) step();
        check("R9 hold ends once ticks resume", 1'b0, 1'b0);
        go_idle();

        // R8: quiet during a receive burst, then release.
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check("R8 quiet mutes receive", 1'b0, 1'b1);
        step();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 transmit free after quiet", 1'b1, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule